// File: doc/BRIEF.md
# Completion Count Interrupt Coalescer

This block serves a single instruction queue. It keeps a 20-bit count of finished instructions that asked to be reported by interrupt. It drives one level-sensitive interrupt line. The line rises once enough completions have built up, or once a hold-off timer has run long enough since the count became nonzero or since the last acknowledge.

Software acknowledges by writing the number of completions it has consumed. That amount is subtracted from the count, and the timer restarts. The interrupt condition is evaluated from the new state straight away. If the remaining count still meets the count threshold, the line goes high again with no wait. A diagnostic port can load the count directly. An enable input masks the line, but counting and timing go on while it is low.

The timer advances on a free-running tick input. The time threshold is given in units of 1024 ticks.

Top module: `cmpl_coalescer`

## Requirements
- R1: Each cycle with `cmpl_pulse` high adds one to the pending count, which is visible on `pend_cnt` after the clock edge.
- R2: A cycle with `ack_we` high subtracts `ack_val` from the pending count. If a completion arrives in the same cycle, the net change is +1 minus `ack_val`. The subtraction is clamped so the count never drops below zero.
- R3: While the pending count is zero, the hold-off timer is held at zero and `irq` is low.
- R4: With `irq_en` high, `irq` is high whenever the pending count is nonzero and at least `num_wait`. A `num_wait` of 0 acts as 1.
- R5: While the count is nonzero, the timer advances by one on each cycle with `tick` high. `irq` is high once the timer reaches `time_wait`×1024. A `time_wait` of 0 disables this condition.
- R6: Any acknowledge write, including a value of 0, restarts the timer from zero. `irq` is then recomputed in the cycle after the write, so it is high again at once if the remaining count still meets `num_wait`.
- R7: While `irq_en` is low, `irq` stays low, but the count and the timer keep changing as usual. Raising `irq_en` exposes the current condition in the same cycle.
- R8: A cycle with `cnt_we` high loads `cnt_wval` into the count. This takes priority over a completion or an acknowledge in the same cycle, and it also restarts the timer.
- R9: The 26-bit timer saturates at all ones instead of wrapping.
- R10: After reset the count and the timer are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_pulse | input | 1 | One completion that requested an interrupt |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_val | input | 20 | Amount to subtract from the count |
| cnt_we | input | 1 | Diagnostic direct count write strobe |
| cnt_wval | input | 20 | Value loaded by a direct count write |
| num_wait | input | 20 | Count threshold |
| time_wait | input | 16 | Time threshold in units of 1024 ticks |
| irq_en | input | 1 | Interrupt output enable |
| tick | input | 1 | Free-running timer tick |
| irq | output | 1 | Level interrupt |
| pend_cnt | output | 20 | Current pending count (acknowledge readback) |

## Verification
The bench covers several corner cases:
- A partial acknowledge that leaves the count above the threshold must raise the line again in the next cycle. A design that waits for the timer would leave the line low.
- A completion and an acknowledge in the same cycle, and an acknowledge larger than the count, must settle to the exact net count or to zero. A design with the wrong priority or no clamp would show a wrong or wrapped count.
- A zero-valued acknowledge must drop a time-triggered interrupt. A design that restarts the timer only on nonzero writes would keep it high.
- The time condition must fire on exactly the 1024th tick. `time_wait`=0 must never fire, `num_wait`=0 must fire on one completion, and a masked interrupt must still show the count that built up.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int CNT_W      = 20;
  localparam int TWAIT_W    = 16;
  localparam int UNIT_SHIFT = 10;
  localparam int TMR_W      = TWAIT_W + UNIT_SHIFT;
endpackage

// File: rtl/coal_count.sv
module coal_count #(
  parameter int CNT_W = coal_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             ack_we_i,
  input  logic [CNT_W-1:0] ack_val_i,
  input  logic             ld_we_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum, take, diff;
  logic             cnt_en;

  // Completion first, then the clamped acknowledge amount.
  always_comb begin
    sum  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, done_i};
    take = '0;
    if (ack_we_i) begin
      take = ({1'b0, ack_val_i} > sum) ? sum : {1'b0, ack_val_i};
    end
    diff   = sum - take;
    cnt_d  = ld_we_i ? ld_val_i : diff[CNT_W-1:0];
    cnt_en = done_i | ack_we_i | ld_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  assert_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !ack_we_i && !ld_we_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && !ld_we_i && !done_i && ack_val_i >= cnt_q) |=> cnt_q == '0);
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we_i |=> cnt_q == $past(ld_val_i));
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int TMR_W = coal_pkg::TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             idle_i,
  output logic [TMR_W-1:0] tmr_o
);
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;

  always_comb begin
    tmr_d = tmr_q;
    if (restart_i || idle_i) begin
      tmr_d = '0;
    end else if (tick_i && tmr_q != '1) begin
      tmr_d = tmr_q + TMR_W'(1);
    end
    tmr_en = restart_i | idle_i | tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  assign tmr_o = tmr_q;

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> tmr_q == '0);
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> tmr_q == '0);
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !restart_i && !idle_i && tmr_q != '1) |=> tmr_q == $past(tmr_q) + TMR_W'(1));
  assert_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == '1 && !restart_i && !idle_i) |=> tmr_q == '1);
endmodule

// File: rtl/coal_eval.sv
module coal_eval #(
  parameter int CNT_W      = coal_pkg::CNT_W,
  parameter int TWAIT_W    = coal_pkg::TWAIT_W,
  parameter int UNIT_SHIFT = coal_pkg::UNIT_SHIFT,
  localparam int TMR_W     = TWAIT_W + UNIT_SHIFT
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [TMR_W-1:0]   tmr_i,
  input  logic [CNT_W-1:0]   num_wait_i,
  input  logic [TWAIT_W-1:0] time_wait_i,
  input  logic               en_i,
  output logic               irq_o
);
  logic [CNT_W-1:0] num_eff;
  logic [TMR_W-1:0] limit;
  logic             cnt_hit, time_hit, pending;

  always_comb begin
    num_eff  = (num_wait_i == '0) ? CNT_W'(1) : num_wait_i;
    limit    = {time_wait_i, {UNIT_SHIFT{1'b0}}};
    pending  = (cnt_i != '0);
    cnt_hit  = (cnt_i >= num_eff);
    time_hit = (time_wait_i != '0) && (tmr_i >= limit);
    irq_o    = en_i && pending && (cnt_hit || time_hit);
  end
endmodule

// File: rtl/cmpl_coalescer.sv
module cmpl_coalescer #(
  parameter int CNT_W      = coal_pkg::CNT_W,
  parameter int TWAIT_W    = coal_pkg::TWAIT_W,
  parameter int UNIT_SHIFT = coal_pkg::UNIT_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmpl_pulse,
  input  logic               ack_we,
  input  logic [CNT_W-1:0]   ack_val,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   cnt_wval,
  input  logic [CNT_W-1:0]   num_wait,
  input  logic [TWAIT_W-1:0] time_wait,
  input  logic               irq_en,
  input  logic               tick,
  output logic               irq,
  output logic [CNT_W-1:0]   pend_cnt
);
  localparam int TMR_W = TWAIT_W + UNIT_SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic             restart, idle;

  assign restart = ack_we | cnt_we;
  assign idle    = (cnt == '0);

  coal_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .done_i(cmpl_pulse),
    .ack_we_i(ack_we), .ack_val_i(ack_val),
    .ld_we_i(cnt_we), .ld_val_i(cnt_wval), .cnt_o(cnt)
  );

  coal_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .restart_i(restart), .idle_i(idle), .tmr_o(tmr)
  );

  coal_eval #(.CNT_W(CNT_W), .TWAIT_W(TWAIT_W), .UNIT_SHIFT(UNIT_SHIFT)) u_eval (
    .cnt_i(cnt), .tmr_i(tmr), .num_wait_i(num_wait),
    .time_wait_i(time_wait), .en_i(irq_en), .irq_o(irq)
  );

  assign pend_cnt = cnt;

  assert_zero_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0) |-> !irq);
  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  assert_count_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && pend_cnt != '0 && pend_cnt >= num_wait) |-> irq);
endmodule

// File: tb/sim_cmpl_coalescer.sv
module sim_cmpl_coalescer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmpl_pulse, ack_we, cnt_we, irq_en, tick, irq;
  logic [19:0] ack_val, cnt_wval, num_wait, pend_cnt;
  logic [15:0] time_wait;
  int          total = 0;
  int          bad = 0;
  bit          done_flag = 0;

  always #10 clk = ~clk;

  cmpl_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse), .ack_we(ack_we),
    .ack_val(ack_val), .cnt_we(cnt_we), .cnt_wval(cnt_wval),
    .num_wait(num_wait), .time_wait(time_wait), .irq_en(irq_en),
    .tick(tick), .irq(irq), .pend_cnt(pend_cnt)
  );

  typedef struct packed {
    logic        d;
    logic        a;
    logic [19:0] av;
    logic [19:0] ec;
    logic        ei;
  } vec_t;

  // num_wait=3, time condition off, enable on
  localparam vec_t VECS [0:10] = '{
    '{1'b1, 1'b0, 20'd0,  20'd1, 1'b0},  // R1
    '{1'b1, 1'b0, 20'd0,  20'd2, 1'b0},  // R1
    '{1'b1, 1'b0, 20'd0,  20'd3, 1'b1},  // R4 threshold reached
    '{1'b0, 1'b1, 20'd1,  20'd2, 1'b0},  // R2
    '{1'b1, 1'b1, 20'd1,  20'd2, 1'b0},  // R2 simultaneous
    '{1'b1, 1'b0, 20'd0,  20'd3, 1'b1},  // R4
    '{1'b1, 1'b0, 20'd0,  20'd4, 1'b1},  // R4
    '{1'b0, 1'b1, 20'd1,  20'd3, 1'b1},  // R6 immediate re-fire
    '{1'b0, 1'b1, 20'd10, 20'd0, 1'b0},  // R2 clamp
    '{1'b0, 1'b0, 20'd0,  20'd0, 1'b0},  // R3
    '{1'b1, 1'b1, 20'd5,  20'd0, 1'b0}   // R2 clamp with completion
  };

  task automatic chk(input string req, input logic [19:0] ec, input logic ei);
    total++;
    if (pend_cnt !== ec || irq !== ei) begin
      bad++;
      $display("FAIL %s: cnt=%0d irq=%b expected cnt=%0d irq=%b", req, pend_cnt, irq, ec, ei);
    end
  endtask

  // Called at a negedge: inputs set, one posedge passes, pulses cleared.
  task automatic step();
    @(negedge clk);
    cmpl_pulse = 1'b0; ack_we = 1'b0; cnt_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmpl_pulse = 0; ack_we = 0; ack_val = 0; cnt_we = 0; cnt_wval = 0;
    num_wait = 20'd3; time_wait = 16'd0; irq_en = 1'b1; tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset", 20'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", 20'd0, 1'b0);

    for (int i = 0; i < 11; i++) begin
      cmpl_pulse = VECS[i].d; ack_we = VECS[i].a; ack_val = VECS[i].av;
      step();
      chk($sformatf("vector %0d (R1 R2 R3 R4 R6)", i), VECS[i].ec, VECS[i].ei);
    end

    // R4: num_wait of 0 acts as 1
    num_wait = 20'd0; #1;
    chk("R4 zero threshold idle", 20'd0, 1'b0);
    cmpl_pulse = 1'b1; step();
    chk("R4 zero threshold acts as one", 20'd1, 1'b1);
    ack_we = 1'b1; ack_val = 20'd1; step();

    // R7: masking keeps counting
    num_wait = 20'd2; irq_en = 1'b0;
    cmpl_pulse = 1'b1; step();
    cmpl_pulse = 1'b1; step();
    chk("R7 masked", 20'd2, 1'b0);
    irq_en = 1'b1; #1;
    chk("R7 unmasked", 20'd2, 1'b1);

    // R8: direct load
    cnt_we = 1'b1; cnt_wval = 20'd7; cmpl_pulse = 1'b1; step();
    chk("R8 direct load", 20'd7, 1'b1);
    ack_we = 1'b1; ack_val = 20'hFFFFF; step();
    chk("R2 full clear", 20'd0, 1'b0);

    // R5: time trigger at 1024 ticks
    num_wait = 20'd100; time_wait = 16'd1; tick = 1'b1;
    cmpl_pulse = 1'b1; step();
    repeat (1023) @(negedge clk);
    chk("R5 before 1024 ticks", 20'd1, 1'b0);
    @(negedge clk);
    chk("R5 at 1024 ticks", 20'd1, 1'b1);
    ack_we = 1'b1; ack_val = 20'd0; step();
    chk("R6 zero ack restarts timer", 20'd1, 1'b0);

    // R5: time_wait 0 disables
    time_wait = 16'd0;
    repeat (1100) @(negedge clk);
    chk("R5 time condition disabled", 20'd1, 1'b0);
    ack_we = 1'b1; ack_val = 20'd1; step();
    chk("R3 back to zero", 20'd0, 1'b0);

    finish_run();
  end
endmodule